// File: doc/BRIEF.md
# Masked-Write Read-Merge-Write Unit

This unit carries out byte-masked writes into memory arrays whose check bits cover a whole longword. Because a partial longword cannot be written without recomputing its check bits, each masked write becomes an indivisible sequence. The unit reads the whole octaword that holds the target, receives the longwords already corrected by the error checker, replaces the selected bytes with host bytes, and writes all four longwords back so that the array can rebuild its check bits.

A host command names a size (longword, quadword or octaword), a longword address, four host longwords and a 4-bit byte mask for each of them. A quadword operation is run as an octaword operation in which the two longwords outside the quadword keep their memory contents. While an operation is open, the unit raises a hold line for the target array, so that the command path that feeds other traffic keeps that array free between the read and the write. Other arrays stay available. If the read reports an uncorrectable error, nothing is written back and a one-cycle error pulse is raised.

Top module: `bytemerge_rmw`

## Requirements
- R1: The size code `cmd_size` selects which longword slots of the octaword take host bytes. The codes are 2'b00 for a longword (only slot `cmd_addr[1:0]`), 2'b01 for a quadword (the two slots whose bit 1 equals `cmd_addr[1]`), and 2'b10 for an octaword (all four slots). The reserved code 2'b11 acts as an octaword. A slot that is not selected is written back with its memory value whatever its mask holds.
- R2: In a selected slot, byte b (bits 8b+7..8b) takes the host byte when mask bit b is 1 and the corrected memory byte when it is 0. Slot s uses data bits 32s+31..32s and mask bits 4s+3..4s.
- R3: `cmd_ready` is 1 only while no operation is open. A command accepted at a clock edge produces `rd_req_valid` in the next cycle with `rd_req_addr` equal to the accepted address. The request stays up until `rd_req_ready` is seen.
- R4: The four read beats (`rd_rsp_valid`) return slots in the order start, start+1, ... modulo 4, where start is `cmd_addr[1:0]`. Idle cycles may appear between beats.
- R5: In the cycle after the last read beat, `wr_valid` is high for exactly four consecutive cycles. These carry slots 0,1,2,3 in order, with `wr_addr` equal to the command address with its low two bits replaced by the slot number.
- R6: If any read beat of an operation has `rd_rsp_dbe` set, no write is issued. `err_dbe` pulses for one cycle, in the cycle after the last beat, and the unit then returns to idle.
- R7: `array_hold` is one-hot on bit `cmd_addr[ADDR_W-1 -: log2(NUM_ARRAYS)]` from the cycle after acceptance through the last write cycle (or the error cycle), and is all zero otherwise.
- R8: Each operation issues exactly one read request, and a read request and a write are never active in the same cycle.
- R9: After reset the unit is idle: `cmd_ready` is 1, and `rd_req_valid`, `wr_valid`, `err_dbe` and `array_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_size | input | 2 | Size code (R1) |
| cmd_addr | input | ADDR_W | Longword address, top bits select the array |
| cmd_data | input | 128 | Host longwords, slot s in bits 32s+31..32s |
| cmd_mask | input | 16 | Byte masks, slot s in bits 4s+3..4s |
| rd_req_valid | output | 1 | Read request to the array |
| rd_req_ready | input | 1 | Array takes the read request |
| rd_req_addr | output | ADDR_W | Read address, low bits give the first slot |
| rd_rsp_valid | input | 1 | Corrected read beat present |
| rd_rsp_data | input | 32 | Corrected read longword |
| rd_rsp_dbe | input | 1 | Beat carries an uncorrectable error |
| wr_valid | output | 1 | Write beat to the array |
| wr_addr | output | ADDR_W | Write longword address |
| wr_data | output | 32 | Merged longword |
| err_dbe | output | 1 | Operation aborted on an uncorrectable error |
| array_hold | output | NUM_ARRAYS | Per-array hold while an operation is open |

## Verification
The bench builds the unit with `NUM_ARRAYS=4` and `ADDR_W=10`, so that the array select is the top two address bits and a short address walks through every hold bit. With these values every read start slot, and so every wrap of the read return order, can be reached with addresses that are easy to read. Gaps between read beats, an error on a middle beat, the reserved size code and all-zero masks are each driven in their own scenario.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int LW_W   = 32;
  localparam int BYTES  = LW_W / 8;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_QUAD = 2'b01,
    SZ_OCTA = 2'b10,
    SZ_RSVD = 2'b11
  } msize_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RREQ,
    ST_RDATA,
    ST_WRITE,
    ST_ABORT
  } rmw_state_t;

  // Does this slot of the octaword take host bytes for the given size?
  function automatic logic slot_selected(msize_t sz, logic [SLOT_W-1:0] start,
                                         logic [SLOT_W-1:0] slot);
    case (sz)
      SZ_LONG: return slot == start;
      SZ_QUAD: return slot[SLOT_W-1] == start[SLOT_W-1];
      default: return 1'b1;
    endcase
  endfunction

  // Byte-wise merge: mask bit 1 picks the host byte.
  function automatic logic [LW_W-1:0] merge_lw(logic [LW_W-1:0] mem,
                                               logic [LW_W-1:0] host,
                                               logic [BYTES-1:0] m);
    logic [LW_W-1:0] r;
    for (int b = 0; b < BYTES; b++)
      r[8*b +: 8] = m[b] ? host[8*b +: 8] : mem[8*b +: 8];
    return r;
  endfunction

  // Slot of the n-th returned beat, wrapping round the octaword.
  function automatic logic [SLOT_W-1:0] beat_slot(logic [SLOT_W-1:0] start,
                                                  logic [SLOT_W-1:0] n);
    return start + n;
  endfunction
endpackage

// File: rtl/rmw_mask_map.sv
module rmw_mask_map
  import rmw_pkg::*;
(
  input  msize_t                    size,
  input  logic [SLOT_W-1:0]         start,
  input  logic [SLOTS*BYTES-1:0]    mask_in,
  output logic [SLOTS*BYTES-1:0]    mask_eff
);
  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic sel;
      assign sel = slot_selected(size, start, SLOT_W'(s));
      assign mask_eff[s*BYTES +: BYTES] = sel ? mask_in[s*BYTES +: BYTES] : '0;
    end
  endgenerate
endmodule

// File: rtl/rmw_merge_buf.sv
module rmw_merge_buf
  import rmw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [SLOT_W-1:0]        cap_slot,
  input  logic [LW_W-1:0]          mem_lw,
  input  logic [SLOTS*LW_W-1:0]    host,
  input  logic [SLOTS*BYTES-1:0]   mask,
  input  logic [SLOT_W-1:0]        rd_slot,
  output logic [LW_W-1:0]          rd_lw
);
  logic [SLOTS-1:0][LW_W-1:0] lanes;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_lane
      logic [LW_W-1:0] q;
      logic            hit;
      assign hit = capture && (cap_slot == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (hit)
          q <= merge_lw(mem_lw, host[s*LW_W +: LW_W], mask[s*BYTES +: BYTES]);
      end
      assign lanes[s] = q;
    end
  endgenerate

  assign rd_lw = lanes[rd_slot];
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_fire,
  input  logic               rd_req_ready,
  input  logic               rsp_valid,
  input  logic               rsp_dbe,
  output rmw_state_t         state,
  output logic [SLOT_W-1:0]  beat_cnt,
  output logic [SLOT_W-1:0]  wr_cnt,
  output logic               ev_read_issue,
  output logic               ev_last_beat,
  output logic               ev_poisoned,
  output logic               ev_write_done
);
  logic dbe_seen;

  assign ev_read_issue = (state == ST_RREQ) && rd_req_ready;
  assign ev_last_beat  = (state == ST_RDATA) && rsp_valid &&
                         (beat_cnt == SLOT_W'(SLOTS-1));
  assign ev_poisoned   = dbe_seen | rsp_dbe;
  assign ev_write_done = (state == ST_WRITE) && (wr_cnt == SLOT_W'(SLOTS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      beat_cnt <= '0;
      wr_cnt   <= '0;
      dbe_seen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:
          if (cmd_fire) state <= ST_RREQ;
        ST_RREQ:
          if (ev_read_issue) begin
            state    <= ST_RDATA;
            beat_cnt <= '0;
            dbe_seen <= 1'b0;
          end
        ST_RDATA:
          if (rsp_valid) begin
            beat_cnt <= beat_cnt + 1'b1;
            dbe_seen <= ev_poisoned;
            if (ev_last_beat) begin
              state  <= ev_poisoned ? ST_ABORT : ST_WRITE;
              wr_cnt <= '0;
            end
          end
        ST_WRITE: begin
          wr_cnt <= wr_cnt + 1'b1;
          if (ev_write_done) state <= ST_IDLE;
        end
        default:
          state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bytemerge_rmw.sv
module bytemerge_rmw
  import rmw_pkg::*;
#(
  parameter int NUM_ARRAYS = 8,
  parameter int ADDR_W     = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [1:0]              cmd_size,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [SLOTS*LW_W-1:0]   cmd_data,
  input  logic [SLOTS*BYTES-1:0]  cmd_mask,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [ADDR_W-1:0]       rd_req_addr,
  input  logic                    rd_rsp_valid,
  input  logic [LW_W-1:0]         rd_rsp_data,
  input  logic                    rd_rsp_dbe,
  output logic                    wr_valid,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [LW_W-1:0]         wr_data,
  output logic                    err_dbe,
  output logic [NUM_ARRAYS-1:0]   array_hold
);
  localparam int ARR_W = (NUM_ARRAYS > 1) ? $clog2(NUM_ARRAYS) : 1;

  rmw_state_t             state;
  logic [SLOT_W-1:0]      beat_cnt, wr_cnt;
  logic                   ev_read_issue, ev_last_beat, ev_poisoned, ev_write_done;
  logic                   ev_accept, busy, capture;
  logic [SLOT_W-1:0]      cap_slot;
  logic [SLOTS*BYTES-1:0] mask_eff;

  logic [ADDR_W-1:0]      addr_q;
  logic [SLOTS*LW_W-1:0]  data_q;
  logic [SLOTS*BYTES-1:0] mask_q;
  logic [ARR_W-1:0]       arr_q;

  assign ev_accept = cmd_valid && cmd_ready;
  assign busy      = (state != ST_IDLE);

  rmw_mask_map u_mask (
    .size     (msize_t'(cmd_size)),
    .start    (cmd_addr[SLOT_W-1:0]),
    .mask_in  (cmd_mask),
    .mask_eff (mask_eff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
      arr_q  <= '0;
    end else if (ev_accept) begin
      addr_q <= cmd_addr;
      data_q <= cmd_data;
      mask_q <= mask_eff;
      arr_q  <= cmd_addr[ADDR_W-1 -: ARR_W];
    end
  end

  rmw_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_fire      (ev_accept),
    .rd_req_ready  (rd_req_ready),
    .rsp_valid     (rd_rsp_valid),
    .rsp_dbe       (rd_rsp_dbe),
    .state         (state),
    .beat_cnt      (beat_cnt),
    .wr_cnt        (wr_cnt),
    .ev_read_issue (ev_read_issue),
    .ev_last_beat  (ev_last_beat),
    .ev_poisoned   (ev_poisoned),
    .ev_write_done (ev_write_done)
  );

  assign capture  = (state == ST_RDATA) && rd_rsp_valid;
  assign cap_slot = beat_slot(addr_q[SLOT_W-1:0], beat_cnt);

  rmw_merge_buf u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .cap_slot (cap_slot),
    .mem_lw   (rd_rsp_data),
    .host     (data_q),
    .mask     (mask_q),
    .rd_slot  (wr_cnt),
    .rd_lw    (wr_data)
  );

  assign cmd_ready    = !busy;
  assign rd_req_valid = (state == ST_RREQ);
  assign rd_req_addr  = addr_q;
  assign wr_valid     = (state == ST_WRITE);
  assign wr_addr      = {addr_q[ADDR_W-1:SLOT_W], wr_cnt};
  assign err_dbe      = (state == ST_ABORT);

  generate
    for (genvar a = 0; a < NUM_ARRAYS; a++) begin : g_hold
      assign array_hold[a] = busy && (arr_q == ARR_W'(a));
    end
  endgenerate
endmodule

// File: rtl/rmw_checker.sv
module rmw_checker #(
  parameter int NUM_ARRAYS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic                  rd_req_valid,
  input logic                  wr_valid,
  input logic                  err_dbe,
  input logic [NUM_ARRAYS-1:0] array_hold
);
  a_r7_hold_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(array_hold));

  a_r7_idle_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (array_hold == '0));

  a_r7_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ((array_hold != '0) && ($past(array_hold) != '0)) |-> $stable(array_hold));

  a_r8_no_read_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r5_write_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |=> wr_valid ##1 wr_valid ##1 wr_valid);

  a_r5_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (array_hold != '0));

  a_r6_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err_dbe |-> (!wr_valid && (array_hold != '0)));

  a_r6_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_dbe |=> (!err_dbe && !wr_valid));
endmodule

bind bytemerge_rmw rmw_checker #(.NUM_ARRAYS(NUM_ARRAYS)) u_rmw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .rd_req_valid (rd_req_valid),
  .wr_valid     (wr_valid),
  .err_dbe      (err_dbe),
  .array_hold   (array_hold)
);

// File: tb/bytemerge_rmw_bench.sv
module bytemerge_rmw_bench;
  localparam int NA = 4;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_size = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [3:0][31:0] cmd_data = '0;
  logic [3:0][3:0] cmd_mask = '0;
  logic rd_req_valid;
  logic rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic rd_rsp_dbe = 1'b0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic err_dbe;
  logic [NA-1:0] array_hold;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bytemerge_rmw #(.NUM_ARRAYS(NA), .ADDR_W(AW)) u_bytemerge_rmw (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_size(cmd_size),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_dbe(rd_rsp_dbe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_dbe(err_dbe), .array_hold(array_hold)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected longword for slot s, built byte by byte from the requirement text.
  function automatic logic [31:0] expect_lw(logic [1:0] sz, logic [1:0] start, int s,
                                            logic [31:0] mem, logic [31:0] host,
                                            logic [3:0] m);
    bit sel;
    logic [31:0] r;
    if (sz == 2'b00)      sel = (s == int'(start));
    else if (sz == 2'b01) sel = ((s / 2) == (int'(start) / 2));
    else                  sel = 1'b1;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = (sel && m[b]) ? host[8*b +: 8] : mem[8*b +: 8];
    return r;
  endfunction

  // One masked-write operation against a modelled array.
  task automatic run_op(string tag, logic [1:0] sz, logic [AW-1:0] a,
                        logic [3:0][31:0] hd, logic [3:0][3:0] hm,
                        logic [3:0][31:0] mem, int bad_beat, int gap);
    logic [NA-1:0] hold_exp;
    logic [1:0] start;
    hold_exp = NA'(1) << a[AW-1 -: 2];
    start = a[1:0];
    @(negedge clk);
    chk({tag, " R3"}, "cmd_ready idle", 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_size = sz; cmd_addr = a; cmd_data = hd; cmd_mask = hm;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_data = '0; cmd_mask = '0;
    chk({tag, " R3"}, "rd_req_valid", 64'(rd_req_valid), 64'd1);
    chk({tag, " R3"}, "rd_req_addr", 64'(rd_req_addr), 64'(a));
    chk({tag, " R3"}, "cmd_ready busy", 64'(cmd_ready), 64'd0);
    chk({tag, " R7"}, "hold after accept", 64'(array_hold), 64'(hold_exp));
    rd_req_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_req_ready = 1'b0;
    chk({tag, " R8"}, "single read request", 64'(rd_req_valid), 64'd0);
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < gap; g++) begin
        chk({tag, " R7"}, "hold in gap", 64'(array_hold), 64'(hold_exp));
        chk({tag, " R8"}, "no write in read", 64'(wr_valid), 64'd0);
        @(posedge clk); @(negedge clk);
      end
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem[2'(start + 2'(k))];  // R4: wrapped return order
      rd_rsp_dbe   = (k == bad_beat);
      @(posedge clk); @(negedge clk);
      rd_rsp_valid = 1'b0; rd_rsp_dbe = 1'b0; rd_rsp_data = '0;
    end
    if (bad_beat >= 0) begin
      chk({tag, " R6"}, "err_dbe pulse", 64'(err_dbe), 64'd1);
      chk({tag, " R6"}, "no write on abort", 64'(wr_valid), 64'd0);
      chk({tag, " R7"}, "hold during abort", 64'(array_hold), 64'(hold_exp));
      @(posedge clk); @(negedge clk);
      chk({tag, " R6"}, "err_dbe drops", 64'(err_dbe), 64'd0);
      chk({tag, " R6"}, "still no write", 64'(wr_valid), 64'd0);
    end else begin
      for (int w = 0; w < 4; w++) begin
        chk({tag, " R5"}, "wr_valid", 64'(wr_valid), 64'd1);
        chk({tag, " R5"}, "wr_addr", 64'(wr_addr), 64'({a[AW-1:2], 2'(w)}));
        chk({tag, " R2"}, "wr_data", 64'(wr_data),
            64'(expect_lw(sz, start, w, mem[w], hd[w], hm[w])));
        chk({tag, " R7"}, "hold in write", 64'(array_hold), 64'(hold_exp));
        chk({tag, " R8"}, "no read in write", 64'(rd_req_valid), 64'd0);
        @(posedge clk); @(negedge clk);
      end
      chk({tag, " R5"}, "burst ends", 64'(wr_valid), 64'd0);
    end
    chk({tag, " R7"}, "hold released", 64'(array_hold), 64'd0);
    chk({tag, " R3"}, "ready again", 64'(cmd_ready), 64'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "cmd_ready", 64'(cmd_ready), 64'd1);
    chk("R9", "rd_req_valid", 64'(rd_req_valid), 64'd0);
    chk("R9", "wr_valid", 64'(wr_valid), 64'd0);
    chk("R9", "err_dbe", 64'(err_dbe), 64'd0);
    chk("R9", "array_hold", 64'(array_hold), 64'd0);
  endtask

  localparam logic [3:0][31:0] MEM_A = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
  localparam logic [3:0][31:0] MEM_B = {32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hCAFE_BABE, 32'h1234_5678};
  localparam logic [3:0][31:0] HOST  = {32'hAAAA_AAA3, 32'hBBBB_BBB2, 32'hCCCC_CCC1, 32'hDDDD_DDD0};

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    // R1 longword, start slot 2, other slots carry full masks that must be ignored
    run_op("long", 2'b00, {2'd0, 8'h06}, HOST, {4'hF, 4'b0101, 4'hF, 4'hF}, MEM_A, -1, 0);
    // R1 quadword upper half, R4 start at slot 3 wraps
    run_op("quad_hi", 2'b01, {2'd1, 8'h17}, HOST, {4'hF, 4'b1001, 4'hF, 4'hF}, MEM_B, -1, 1);
    // R1 quadword lower half
    run_op("quad_lo", 2'b01, {2'd2, 8'h20}, HOST, {4'hF, 4'hF, 4'b0110, 4'b0011}, MEM_A, -1, 0);
    // R1 R2 octaword, varied masks, start slot 1, gaps between beats
    run_op("octa", 2'b10, {2'd3, 8'h31}, HOST, {4'b1000, 4'b0001, 4'b1111, 4'b0000}, MEM_B, -1, 2);
    // R1 reserved size acts as octaword
    run_op("rsvd", 2'b11, {2'd1, 8'h42}, HOST, {4'b0010, 4'b0100, 4'b1000, 4'b0001}, MEM_A, -1, 0);
    // R2 all-zero masks write memory back unchanged
    run_op("zeromask", 2'b10, {2'd2, 8'h53}, HOST, '0, MEM_B, -1, 0);
    // R6 uncorrectable error on a middle beat
    run_op("dbe_mid", 2'b10, {2'd3, 8'h61}, HOST, {4'hF, 4'hF, 4'hF, 4'hF}, MEM_A, 1, 1);
    // R6 uncorrectable error on the last beat
    run_op("dbe_last", 2'b00, {2'd0, 8'h70}, HOST, {4'hF, 4'hF, 4'hF, 4'hF}, MEM_B, 3, 0);
    // After abort the unit works normally again
    run_op("recover", 2'b10, {2'd0, 8'h73}, HOST, {4'b1111, 4'b0000, 4'b1010, 4'b0101}, MEM_A, -1, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule